// File: doc/BRIEF.md
# Fractional Multiply-Accumulate Execute Stage

This block is the arithmetic execute stage of a 32-bit audio signal processor. Each accepted operation carries a 4-bit opcode and three signed operands, A, X and Y. One clock later the block presents a result word, a 9-bit condition word and flags for saturation and unsupported opcodes. The arithmetic is two's-complement Q31 fractional or plain integer, depending on the opcode. A hidden accumulator register is updated only by the accumulate-only opcode.

The opcodes cover several groups. Four multiply-accumulate forms combine A with the product X·Y shifted right by 31, either added or negated, and either clamped or wrapped. Two integer forms use the unshifted product. The rest are a three-input add, a bitwise mask-and-flip, three compare-and-select forms, and a fractional interpolation between A and Y weighted by X. Opcodes 12, 13 and 15 are not implemented here: they pass A through and raise an unsupported flag. Register-file fetch and instruction decode are done by the surrounding pipeline.

Top module: `q31_fx_alu`

## Requirements
- R1: An operation presented with `in_vld` high is registered at the next rising edge. `out_vld` is high in the cycle that follows, and `res`, `cc`, `sat_evt` and `unsup` hold that operation's outputs. When `in_vld` is low, `out_vld` is low one cycle later. Reset clears `out_vld` and the accumulator.
- R2: Opcode 0 gives sat(A + (X·Y >>> 31)) and opcode 1 gives sat(A − (X·Y >>> 31)). In both, the product and the sum are exact, and sat clamps to 0x7FFFFFFF or 0x80000000.
- R3: Opcodes 2 and 3 compute the same sums as opcodes 0 and 1, but keep only the low 32 bits (wraparound) and never saturate.
- R4: Opcode 4 gives sat(A + X·Y) using the full integer product. Opcode 5 gives the low 31 bits of A + X·Y, with bit 31 forced to 0.
- R5: Opcode 6 gives sat(A + X + Y).
- R6: Opcode 7 returns A and adds the low 32 bits of (X·Y >>> 31) into the accumulator, wrapping. No other opcode, and no cycle with `in_vld` low, changes `acc_out`.
- R7: Opcode 8 gives (A AND X) XOR Y.
- R8: All compares are signed. Opcode 9 gives X when A ≥ Y, else NOT X. Opcode 10 gives X when A ≥ Y, else Y. Opcode 11 gives X when A < Y, else Y.
- R9: Opcode 14 gives sat(A + ((X·(Y − A)) >>> 31)), with every intermediate exact.
- R10: Opcodes 12, 13 and 15 return A with `unsup` high. Every other opcode returns with `unsup` low.
- R11: Condition bits describe the final result. Bit 2 is minus (bit 31 of the result). Bit 3 is zero. Bit 8 is nonzero. Bit 0 is normalized, meaning result bit 31 differs from bit 30. Bits 5 to 7 are 0.
- R12: Condition bit 1 (borrow) is high when A < Y signed, for every opcode. Condition bit 4 and `sat_evt` are high exactly when a saturating opcode clamped its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_vld | input | 1 | Operation present |
| op | input | 4 | Opcode |
| a | input | 32 | Operand A (signed) |
| x | input | 32 | Operand X (signed) |
| y | input | 32 | Operand Y (signed) |
| out_vld | output | 1 | Result valid |
| res | output | 32 | Result |
| cc | output | 9 | Condition word |
| sat_evt | output | 1 | Saturation occurred this result |
| unsup | output | 1 | Opcode not implemented |
| acc_out | output | 32 | Accumulator contents |

## Verification
The bench builds the block at its default width of 32, so that the clamp limits and the Q31 shift match the 128-bit reference model in the bench. Operands built from the extremes 0x7FFFFFFF, 0x80000000, 0, 1 and −1 are run through all sixteen opcodes. These reach the extreme-by-extreme products, including the single Q31 product that overflows to +1.0, as well as both clamp directions and equal-operand compares. Random operands then cover the general case, and an idle accumulate checks that the accumulator ignores cycles without a valid operation.

// File: rtl/q31_fx_alu.sv
module q31_fx_alu #(
  parameter int W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_vld,
  input  logic [3:0]          op,
  input  logic signed [W-1:0] a,
  input  logic signed [W-1:0] x,
  input  logic signed [W-1:0] y,
  output logic                out_vld,
  output logic [W-1:0]        res,
  output logic [8:0]          cc,
  output logic                sat_evt,
  output logic                unsup,
  output logic [W-1:0]        acc_out
);
  localparam int WL = 2*W + 8;
  localparam logic signed [WL-1:0] HI = {{(W+9){1'b0}}, {(W-1){1'b1}}};
  localparam logic signed [WL-1:0] LO = ~HI;

  logic signed [WL-1:0] a_w, x_w, y_w, prod_w, frac_w, ip_w, wide;
  logic [W-1:0] r;
  logic sat_op, sat_hit, uns, lt;

  assign a_w    = a;
  assign x_w    = x;
  assign y_w    = y;
  assign prod_w = x_w * y_w;
  assign frac_w = prod_w >>> (W-1);
  assign ip_w   = (x_w * (y_w - a_w)) >>> (W-1);
  assign lt     = a < y;

  always_comb begin
    wide   = '0;
    sat_op = 1'b0;
    uns    = 1'b0;
    r      = a;
    case (op)
      4'd0:  begin wide = a_w + frac_w; sat_op = 1'b1; end
      4'd1:  begin wide = a_w - frac_w; sat_op = 1'b1; end
      4'd2:  begin wide = a_w + frac_w; r = wide[W-1:0]; end
      4'd3:  begin wide = a_w - frac_w; r = wide[W-1:0]; end
      4'd4:  begin wide = a_w + prod_w; sat_op = 1'b1; end
      4'd5:  begin wide = a_w + prod_w; r = {1'b0, wide[W-2:0]}; end
      4'd6:  begin wide = a_w + x_w + y_w; sat_op = 1'b1; end
      4'd7:  r = a;
      4'd8:  r = (a & x) ^ y;
      4'd9:  r = lt ? ~x : x;
      4'd10: r = lt ? y : x;
      4'd11: r = lt ? x : y;
      4'd14: begin wide = a_w + ip_w; sat_op = 1'b1; end
      default: uns = 1'b1;
    endcase
    sat_hit = 1'b0;
    if (sat_op) begin
      if (wide > HI) begin
        r = HI[W-1:0]; sat_hit = 1'b1;
      end else if (wide < LO) begin
        r = LO[W-1:0]; sat_hit = 1'b1;
      end else begin
        r = wide[W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
      res     <= '0;
      cc      <= '0;
      sat_evt <= 1'b0;
      unsup   <= 1'b0;
      acc_out <= '0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) begin
        res     <= r;
        cc      <= {|r, 3'b000, sat_hit, ~|r, r[W-1], lt, r[W-1] ^ r[W-2]};
        sat_evt <= sat_hit;
        unsup   <= uns;
        if (op == 4'd7) acc_out <= acc_out + frac_w[W-1:0];
      end else begin
        sat_evt <= 1'b0;
      end
    end
  end

  p_vld_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> out_vld);
  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> !out_vld);
  p_acc_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_vld && op == 4'd7) |=> $stable(acc_out));
  p_sel_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && op == 4'd10) |=> (res == $past(x) || res == $past(y)));
  p_unsup_echo_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && (op == 4'd12 || op == 4'd13 || op == 4'd15)) |=> (unsup && res == $past(a)));
  p_clamp_val_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && sat_evt) |-> (res == HI[W-1:0] || res == LO[W-1:0]));
endmodule

// File: tb/q31_fx_alu_tb_top.sv
module q31_fx_alu_tb_top;
  localparam int CLK_NS = 10;

  typedef struct packed {
    logic [3:0]  op;
    logic [31:0] res;
    logic [8:0]  cc;
    logic        sat;
    logic        uns;
    logic [31:0] acc;
  } exp_t;

  logic clk = 0, rst_n = 0, in_vld = 0;
  logic [3:0] op = 0;
  logic signed [31:0] a = 0, x = 0, y = 0;
  logic out_vld, sat_evt, unsup;
  logic [31:0] res, acc_out;
  logic [8:0] cc;

  int checks = 0, errors = 0;
  exp_t q[$];
  logic [31:0] m_acc = 0;
  logic done = 0;

  always #(CLK_NS/2) clk = ~clk;

  q31_fx_alu dut_i (.clk(clk), .rst_n(rst_n), .in_vld(in_vld), .op(op), .a(a), .x(x), .y(y),
    .out_vld(out_vld), .res(res), .cc(cc), .sat_evt(sat_evt), .unsup(unsup), .acc_out(acc_out));

  function automatic string req_of(logic [3:0] o);
    case (o)
      0, 1: return "R2";
      2, 3: return "R3";
      4, 5: return "R4";
      6: return "R5";
      7: return "R6";
      8: return "R7";
      9, 10, 11: return "R8";
      14: return "R9";
      default: return "R10";
    endcase
  endfunction

  function automatic exp_t model(logic [3:0] o, logic signed [31:0] av, logic signed [31:0] xv,
                                 logic signed [31:0] yv, logic [31:0] acc_in);
    logic signed [127:0] A, X, Y, P, F, S;
    logic [31:0] r;
    logic s, u, so;
    exp_t e;
    A = av; X = xv; Y = yv;
    P = X * Y; F = P >>> 31;
    S = 0; so = 0; u = 0; r = av;
    e.acc = acc_in;
    case (o)
      0: begin S = A + F; so = 1; end
      1: begin S = A - F; so = 1; end
      2: r = 32'(A + F);
      3: r = 32'(A - F);
      4: begin S = A + P; so = 1; end
      5: begin S = A + P; r = {1'b0, S[30:0]}; end
      6: begin S = A + X + Y; so = 1; end
      7: e.acc = acc_in + F[31:0];
      8: r = (av & xv) ^ yv;
      9: r = (av >= yv) ? xv : ~xv;
      10: r = (av >= yv) ? xv : yv;
      11: r = (av < yv) ? xv : yv;
      14: begin S = A + ((X * (Y - A)) >>> 31); so = 1; end
      default: u = 1;
    endcase
    s = 0;
    if (so) begin
      if (S > 128'sd2147483647) begin r = 32'h7FFFFFFF; s = 1; end
      else if (S < -128'sd2147483648) begin r = 32'h80000000; s = 1; end
      else r = S[31:0];
    end
    e.op = o; e.res = r; e.sat = s; e.uns = u;
    e.cc = {(r != 0), 3'b000, s, (r == 0), r[31], (av < yv), r[31] ^ r[30]};
    return e;
  endfunction

  task automatic check(string rq, string what, logic [63:0] act, logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, expv);
    end
  endtask

  task automatic drive(logic [3:0] o, logic [31:0] av, logic [31:0] xv, logic [31:0] yv);
    exp_t e;
    @(negedge clk);
    e = model(o, av, xv, yv, m_acc);
    m_acc = e.acc;
    q.push_back(e);
    op = o; a = av; x = xv; y = yv; in_vld = 1;
  endtask

  always @(posedge clk) begin
    #2;
    if (rst_n && out_vld) begin
      if (q.size() == 0) check("R1", "unexpected out_vld", 1, 0);
      else begin
        exp_t e;
        string rq;
        e = q.pop_front();
        rq = req_of(e.op);
        check(rq, "res", 64'(res), 64'(e.res));
        check("R11", "cc", 64'(cc & 9'h1FD), 64'(e.cc & 9'h1FD));
        check("R12", "borrow", 64'(cc[1]), 64'(e.cc[1]));
        check("R12", "sat_evt", 64'(sat_evt), 64'(e.sat));
        check("R10", "unsup", 64'(unsup), 64'(e.uns));
        check("R6", "acc_out", 64'(acc_out), 64'(e.acc));
      end
    end
  end

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] corner [5];
    corner[0] = 32'h7FFFFFFF; corner[1] = 32'h80000000; corner[2] = 0;
    corner[3] = 1; corner[4] = 32'hFFFFFFFF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1", "reset out_vld", 64'(out_vld), 0);
    check("R6", "reset acc", 64'(acc_out), 0);

    for (int o = 0; o < 16; o++)
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++)
          for (int k = 0; k < 5; k++)
            drive(4'(o), corner[i], corner[j], corner[k]);

    for (int n = 0; n < 3000; n++)
      drive(4'($urandom_range(0, 15)), $urandom, $urandom, $urandom);

    // R6 / R1: an accumulate with in_vld low is ignored
    @(negedge clk);
    in_vld = 0; op = 4'd7; x = 32'h40000000; y = 32'h40000000;
    repeat (3) @(negedge clk);
    check("R1", "idle out_vld", 64'(out_vld), 0);
    check("R6", "idle acc", 64'(acc_out), 64'(m_acc));

    drive(4'd0, 32'h7FFFFFFF, 32'h7FFFFFFF, 32'h7FFFFFFF);
    @(negedge clk);
    in_vld = 0;
    repeat (4) @(negedge clk);
    check("R1", "queue drained", 64'(q.size()), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule